// File: doc/BRIEF.md
# T1/J1 Superframe Framing-Bit Generator

This block sits in the transmit path of a T1 or J1 line interface. It receives a serial stream with one bit per clock. The stream is organised as 193-bit frames: a framing slot, then 24 eight-bit channels sent most significant bit first. The block counts its way through a twelve-frame superframe and writes the superframe alignment sequence into each framing slot. Every other bit passes through with one clock of delay, unless a diagnostic or alarm option rewrites it.

The options are as follows:
- A one-shot corruption of a single odd-frame or even-frame framing bit, for testing far-end error counters.
- A mimic mode that copies each framing bit into the bit that follows it.
- Remote (yellow) alarm signalling, started manually or taken automatically from the receive-side red alarm. It is carried in channel data in T1 mode and in the last framing bit in J1 mode.
- A global disable that turns the block into a pure one-cycle delay.

A superframe-start strobe marks the framing slot of frame 1 and realigns the internal counters.

Top module: `t1sf_fbit_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `bit_out` becomes 0 and both pending invert requests clear. After reset, the first input bit is treated as the framing slot of frame 1, with no strobe needed.
- R2: With `frame_dis`=0 in T1 mode, the framing slots of frames 1 to 12 carry 1,0,0,0,1,1,0,1,1,1,0,0 in that order.
- R3: In J1 mode, frames 1 to 11 carry the same framing bits as T1. The framing bit of frame 12 is 1 while a yellow alarm is sent and 0 otherwise.
- R4: A one-cycle pulse on `ft_inv_req` is held pending. It inverts exactly one framing bit of an odd-numbered frame (1,3,...,11): the next such slot seen with `frame_dis`=0. Later odd frames are not affected.
- R5: A one-cycle pulse on `fs_inv_req` works the same way, but on exactly one framing bit of an even-numbered frame (2,4,...,12).
- R6: With `mimic_en`=1 and `frame_dis`=0, the bit right after each framing slot (bit 1 of the frame) is output equal to the framing bit just sent.
- R7: In T1 mode with a yellow alarm active and `frame_dis`=0, the second bit of every channel is output as 0. These are frame bit positions 2, 10, ..., 186. In J1 mode the channel bits are not touched.
- R8: A yellow alarm is active when `yel_manual`=1, or when both `auto_yel_en`=1 and `red_alarm`=1. A red alarm alone with `auto_yel_en`=0 has no effect.
- R9: With `frame_dis`=1, every bit, including framing slots, is output unchanged. No invert is consumed: a pending request stays pending until framing is enabled again.
- R10: `sf_start`=1 marks the current input bit as the framing slot of frame 1, whatever the counter state. Counting then continues from there.
- R11: Bits that no rule rewrites appear on `bit_out` exactly one clock after they are presented on `bit_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Serial transmit data, one bit per clock |
| sf_start | input | 1 | Marks the current bit as the frame-1 framing slot |
| j1_mode | input | 1 | 1 = J1 variant, 0 = T1 |
| frame_dis | input | 1 | 1 = pass all bits through unchanged |
| mimic_en | input | 1 | Copy each framing bit into the following bit |
| yel_manual | input | 1 | Force yellow alarm transmission |
| auto_yel_en | input | 1 | Let the receive red alarm raise yellow |
| red_alarm | input | 1 | Receive-side red alarm declared |
| ft_inv_req | input | 1 | Pulse: corrupt the next odd-frame framing bit |
| fs_inv_req | input | 1 | Pulse: corrupt the next even-frame framing bit |
| bit_out | output | 1 | Modified serial stream, one clock behind `bit_in` |

## Verification
A wrong superframe position shows up within one frame (193 clocks): the framing slot carries the wrong alignment bit, or the yellow-forced zeros land off the second bit of each channel. A frame-count error that keeps the bit position right shows up at the latest when the 12-frame sequence fails to match within one superframe. A stuck or duplicated invert latch appears as a second corrupted framing bit in the following superframe, or as none at all. A mimic register holding a stale value shows up at bit 1 of the very next frame.

// File: rtl/sf_pkg.sv
// Package: shared constants, types and the alignment-sequence lookup
// for the T1/J1 superframe framing-bit generator.
// Assumes a 193-bit frame of one framing slot plus 24 eight-bit channels.
package sf_pkg;
    localparam int FRAME_BITS = 193;
    localparam int SF_FRAMES  = 12;
    localparam int CHAN_BITS  = 8;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int FRM_W      = $clog2(SF_FRAMES);

    // Alignment sequence, frame 1 in the most significant position.
    localparam logic [SF_FRAMES-1:0] ALIGN_SEQ = 12'b1000_1101_1100;

    // Static control seen by the bit multiplexer.
    typedef struct packed {
        logic j1;
        logic dis;
        logic mimic;
        logic yellow;
    } sf_ctrl_t;

    // Return the alignment bit for frame index 0..SF_FRAMES-1.
    function automatic logic align_bit(input logic [FRM_W-1:0] idx);
        return ALIGN_SEQ[FRM_W'(SF_FRAMES - 1) - idx];
    endfunction
endpackage

// File: rtl/sf_pos_counter.sv
// Module: tracks bit position within the frame and frame index within
// the superframe. The strobe overrides the count for the current bit,
// so the current position is valid in the same cycle as the strobe.
// Assumes the strobe, when present, coincides with a frame-1 framing slot.
module sf_pos_counter
    import sf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sf_start,
    output logic [BIT_W-1:0] cur_bit,
    output logic [FRM_W-1:0] cur_frm,
    output logic             is_fslot
);
    logic [BIT_W-1:0] cnt_bit;
    logic [FRM_W-1:0] cnt_frm;
    logic [BIT_W-1:0] nxt_bit;
    logic [FRM_W-1:0] nxt_frm;

    // Current position: strobe forces frame 1, slot 0.
    always_comb begin
        cur_bit  = sf_start ? '0 : cnt_bit;
        cur_frm  = sf_start ? '0 : cnt_frm;
        is_fslot = (cur_bit == '0);
    end

    // Successor of the current position with frame and superframe wrap.
    always_comb begin
        nxt_bit = cur_bit + BIT_W'(1);
        nxt_frm = cur_frm;
        if (cur_bit == BIT_W'(FRAME_BITS - 1)) begin
            nxt_bit = '0;
            nxt_frm = (cur_frm == FRM_W'(SF_FRAMES - 1)) ? '0 : cur_frm + FRM_W'(1);
        end
    end

    // Position registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_bit <= '0;
            cnt_frm <= '0;
        end else begin
            cnt_bit <= nxt_bit;
            cnt_frm <= nxt_frm;
        end
    end
endmodule

// File: rtl/sf_inv_latch.sv
// Module: holds a one-shot invert request from a single-cycle pulse
// until an eligible framing slot consumes it.
// Assumes the caller qualifies 'eligible' with the frame parity and enable.
module sf_inv_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic eligible,
    output logic pend,
    output logic apply
);
    // Consume only a request already registered.
    always_comb apply = pend && eligible;

    // Set on request, clear once applied.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= (pend && !eligible) || req;
    end
endmodule

// File: rtl/sf_bit_mux.sv
// Module: selects each output bit among pass-through, framing bit,
// mimic copy and yellow-forced zero, and registers it.
// Assumes the position inputs describe the bit presented on bit_in.
module sf_bit_mux
    import sf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic [BIT_W-1:0] cur_bit,
    input  logic [FRM_W-1:0] cur_frm,
    input  logic             is_fslot,
    input  sf_ctrl_t         ctrl,
    input  logic             inv_hit,
    output logic             bit_out
);
    logic             fbit_val;
    logic             last_fbit;
    logic             chan_b2;
    logic [BIT_W-1:0] chan_off;
    logic             nxt_out;

    // Framing-bit value for this frame, J1 frame 12 carrying yellow.
    always_comb begin
        fbit_val = align_bit(cur_frm);
        if (ctrl.j1 && cur_frm == FRM_W'(SF_FRAMES - 1)) fbit_val = ctrl.yellow;
        fbit_val = fbit_val ^ inv_hit;
    end

    // Second bit of a channel: offset from bit 1 is 1 modulo channel width.
    always_comb begin
        chan_off = cur_bit - BIT_W'(1);
        chan_b2  = !is_fslot && ((chan_off % BIT_W'(CHAN_BITS)) == BIT_W'(1));
    end

    // Output selection in priority order.
    always_comb begin
        nxt_out = bit_in;
        if (!ctrl.dis) begin
            if (is_fslot)                                   nxt_out = fbit_val;
            else if (ctrl.mimic && cur_bit == BIT_W'(1))    nxt_out = last_fbit;
            else if (!ctrl.j1 && ctrl.yellow && chan_b2)    nxt_out = 1'b0;
        end
    end

    // Output register and copy of the last framing bit for mimic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_out   <= 1'b0;
            last_fbit <= 1'b0;
        end else begin
            bit_out <= nxt_out;
            if (is_fslot) last_fbit <= fbit_val;
        end
    end
endmodule

// File: rtl/t1sf_fbit_gen.sv
// Module: top of the T1/J1 superframe framing-bit generator.
// Joins the position counter, two invert latches (odd/even frames) and
// the bit multiplexer. Output lags input by one clock.
// Assumes one data bit per clock and static controls within a frame.
module t1sf_fbit_gen
    import sf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic sf_start,
    input  logic j1_mode,
    input  logic frame_dis,
    input  logic mimic_en,
    input  logic yel_manual,
    input  logic auto_yel_en,
    input  logic red_alarm,
    input  logic ft_inv_req,
    input  logic fs_inv_req,
    output logic bit_out
);
    logic [BIT_W-1:0] cur_bit;
    logic [FRM_W-1:0] cur_frm;
    logic             is_fslot;
    logic [1:0]       inv_req;
    logic [1:0]       inv_pend;
    logic [1:0]       inv_apply;
    sf_ctrl_t         ctrl;

    // Gather controls; yellow from manual or qualified red alarm.
    always_comb begin
        ctrl.j1     = j1_mode;
        ctrl.dis    = frame_dis;
        ctrl.mimic  = mimic_en;
        ctrl.yellow = yel_manual || (auto_yel_en && red_alarm);
        inv_req     = {fs_inv_req, ft_inv_req};
    end

    sf_pos_counter u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .sf_start (sf_start),
        .cur_bit  (cur_bit),
        .cur_frm  (cur_frm),
        .is_fslot (is_fslot)
    );

    // Index 0 serves odd frames (even index), index 1 even frames.
    for (genvar k = 0; k < 2; k++) begin : g_inv
        sf_inv_latch u_lat (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (inv_req[k]),
            .eligible (is_fslot && !frame_dis && (cur_frm[0] == 1'(k))),
            .pend     (inv_pend[k]),
            .apply    (inv_apply[k])
        );
    end

    sf_bit_mux u_mux (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (bit_in),
        .cur_bit  (cur_bit),
        .cur_frm  (cur_frm),
        .is_fslot (is_fslot),
        .ctrl     (ctrl),
        .inv_hit  (|inv_apply),
        .bit_out  (bit_out)
    );
endmodule

// File: rtl/sf_fbit_chk.sv
// Checker: temporal properties of the framing-bit generator, bound to the top.
module sf_fbit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_in,
    input logic       bit_out,
    input logic       sf_start,
    input logic       j1_mode,
    input logic       frame_dis,
    input logic       mimic_en,
    input logic       yel_manual,
    input logic       auto_yel_en,
    input logic       red_alarm,
    input logic [7:0] cur_bit,
    input logic [3:0] cur_frm,
    input logic       is_fslot,
    input logic       ft_pend,
    input logic       fs_pend
);
    logic armed;
    logic armed2;
    logic yel;

    // Track cycles since reset so $past never reaches into reset.
    always_ff @(posedge clk) begin
        armed  <= rst_n;
        armed2 <= rst_n && armed;
    end

    always_comb yel = yel_manual || (auto_yel_en && red_alarm);

    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (!bit_out && !ft_pend && !fs_pend));

    a_r9_dis_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(frame_dis)) |-> (bit_out == $past(bit_in)));

    a_r7_t1_yellow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(!frame_dis && !j1_mode && yel && cur_bit[2:0] == 3'd2))
        |-> !bit_out);

    a_r6_mimic_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (armed2 && $past(!frame_dis && mimic_en && cur_bit == 8'd1) && $past(!frame_dis, 2))
        |-> (bit_out == $past(bit_out)));

    a_r4_ft_consumed_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(ft_pend)) |-> $past(is_fslot && !cur_frm[0] && !frame_dis));

    a_r5_fs_consumed_even: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(fs_pend)) |-> $past(is_fslot && cur_frm[0] && !frame_dis));

    a_r10_resync: assert property (@(posedge clk) disable iff (!rst_n)
        sf_start |=> (sf_start || (cur_bit == 8'd1 && cur_frm == 4'd0)));
endmodule

bind t1sf_fbit_gen sf_fbit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_in      (bit_in),
    .bit_out     (bit_out),
    .sf_start    (sf_start),
    .j1_mode     (j1_mode),
    .frame_dis   (frame_dis),
    .mimic_en    (mimic_en),
    .yel_manual  (yel_manual),
    .auto_yel_en (auto_yel_en),
    .red_alarm   (red_alarm),
    .cur_bit     (cur_bit),
    .cur_frm     (cur_frm),
    .is_fslot    (is_fslot),
    .ft_pend     (inv_pend[0]),
    .fs_pend     (inv_pend[1])
);

// File: tb/t1sf_fbit_gen_tb.sv
module t1sf_fbit_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [11:0] SEQ = 12'b1000_1101_1100;
    // Row: {j1, yel_manual, auto_yel_en, red_alarm, mimic, exp_f12_j1, exp_b2_forced}
    localparam int NROW = 9;
    localparam logic [6:0] ROWS [NROW] = '{
        7'b0_0_0_0_0_0_0,   // T1 plain (R2)
        7'b0_0_0_0_1_0_0,   // T1 mimic (R6)
        7'b0_1_0_0_0_0_1,   // T1 manual yellow (R7, R8)
        7'b0_0_1_1_0_0_1,   // T1 auto yellow from red (R8)
        7'b0_0_0_1_0_0_0,   // red without auto: no effect (R8)
        7'b1_0_0_0_0_0_0,   // J1 plain (R3)
        7'b1_1_0_0_1_1_0,   // J1 manual yellow + mimic (R3, R6)
        7'b1_0_1_1_0_1_0,   // J1 auto yellow (R3, R8)
        7'b0_0_1_0_1_0_0    // auto without red: no yellow (R8)
    };

    logic clk = 1'b0, rst_n = 1'b0, bit_in = 1'b0, sf_start = 1'b0;
    logic j1_mode = 1'b0, frame_dis = 1'b0, mimic_en = 1'b0, yel_manual = 1'b0;
    logic auto_yel_en = 1'b0, red_alarm = 1'b0, ft_inv_req = 1'b0, fs_inv_req = 1'b0;
    logic bit_out;
    int   total = 0;
    int   bad = 0;

    t1sf_fbit_gen u_dut (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .sf_start(sf_start),
        .j1_mode(j1_mode), .frame_dis(frame_dis), .mimic_en(mimic_en),
        .yel_manual(yel_manual), .auto_yel_en(auto_yel_en), .red_alarm(red_alarm),
        .ft_inv_req(ft_inv_req), .fs_inv_req(fs_inv_req), .bit_out(bit_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Present one bit at a falling edge; return output one clock later.
    task automatic step(input logic b, input logic sf, output logic o);
        bit_in   = b;
        sf_start = sf;
        @(negedge clk);
        o = bit_out;
        sf_start = 1'b0;
    endtask

    // One superframe from a strobe, checking every framing slot and all other bits.
    task automatic run_sf(input logic j1, ym, ay, red, mim, dis,
                          input logic [11:0] flip, input logic exp12, input logic force_b2,
                          input string tag);
        logic yel, fb, o, e, in;
        logic [11:0] fexp;
        int errs;
        j1_mode = j1; yel_manual = ym; auto_yel_en = ay; red_alarm = red;
        mimic_en = mim; frame_dis = dis;
        yel = ym || (ay && red);
        for (int i = 0; i < 12; i++) begin
            fb = SEQ[11-i];
            if (j1 && i == 11) fb = exp12;
            fexp[i] = fb ^ flip[i];
        end
        errs = 0;
        for (int f = 0; f < 12; f++) begin
            for (int p = 0; p < 193; p++) begin
                in = ((p + f) % 3 != 0);
                step(in, (f == 0 && p == 0), o);
                if (dis)                         e = in;
                else if (p == 0)                 e = fexp[f];
                else if (p == 1 && mim)          e = fexp[f];
                else if (!j1 && yel && (p % 8) == 2) e = 1'b0;
                else                             e = in;
                if (p == 0) check(o, e, $sformatf("%s frame %0d F-slot", tag, f + 1));
                else if (o !== e) errs++;
            end
        end
        if (!j1 && yel && !dis) check(force_b2, 1'b1, {tag, " table forced-bit flag"});
        total++;
        if (errs != 0) begin
            bad++;
            $display("FAIL %s R11 payload: actual=%0d mismatches expected=0", tag, errs);
        end
    endtask

    task automatic pulse(input logic ft, input logic fs);
        logic o;
        ft_inv_req = ft;
        fs_inv_req = fs;
        step(1'b0, 1'b0, o);
        ft_inv_req = 1'b0;
        fs_inv_req = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic o;
        // R1: reset state, then free-running count starts at frame 1 slot 0.
        repeat (3) @(negedge clk);
        check(bit_out, 1'b0, "R1 output in reset");
        rst_n = 1'b1;
        step(1'b0, 1'b0, o);
        check(o, 1'b1, "R1 first bit after reset is frame-1 F-slot");
        step(1'b0, 1'b0, o);
        check(o, 1'b0, "R1 R11 bit 1 passes through");

        // Table walk of configurations.
        for (int r = 0; r < NROW; r++) begin
            run_sf(ROWS[r][6], ROWS[r][5], ROWS[r][4], ROWS[r][3], ROWS[r][2], 1'b0,
                   12'b0, ROWS[r][1], ROWS[r][0],
                   $sformatf("row%0d R2/R3/R6/R7/R8", r));
        end

        // R10: strobe arrives mid-frame after an offset.
        for (int i = 0; i < 57; i++) step(1'b1, 1'b0, o);
        run_sf(0, 0, 0, 0, 0, 0, 12'b0, 0, 0, "R10 resync");

        // R4: single odd-frame inversion, then a clean superframe.
        pulse(1'b1, 1'b0);
        run_sf(0, 0, 0, 0, 0, 0, 12'b0000_0000_0001, 0, 0, "R4 Ft invert");
        run_sf(0, 0, 0, 0, 0, 0, 12'b0, 0, 0, "R4 Ft single-shot");

        // R5: single even-frame inversion, then clean.
        pulse(1'b0, 1'b1);
        run_sf(0, 0, 0, 0, 1, 0, 12'b0000_0000_0010, 0, 0, "R5 Fs invert");
        run_sf(0, 0, 0, 0, 0, 0, 12'b0, 0, 0, "R5 Fs single-shot");

        // R4 and R5 together in J1 with yellow.
        pulse(1'b1, 1'b1);
        run_sf(1, 1, 0, 0, 0, 0, 12'b0000_0000_0011, 1, 0, "R4 R5 both");

        // R9: disabled pass-through, pending request survives.
        run_sf(0, 1, 0, 0, 1, 1, 12'b0, 0, 0, "R9 disabled");
        pulse(1'b1, 1'b0);
        run_sf(0, 1, 0, 0, 1, 1, 12'b0, 0, 0, "R9 disabled keeps pending");
        run_sf(0, 0, 0, 0, 0, 0, 12'b0000_0000_0001, 0, 0, "R9 pending applied");

        // R1: reset mid-stream clears a pending request.
        pulse(1'b0, 1'b1);
        rst_n = 1'b0;
        step(1'b1, 1'b0, o);
        check(bit_out, 1'b0, "R1 output after mid-run reset");
        rst_n = 1'b1;
        run_sf(0, 0, 0, 0, 0, 0, 12'b0, 0, 0, "R1 pending cleared");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule